// File: doc/BRIEF.md
# Program Memory Table Access Unit

This block lets a CPU move data between its 16-bit data path and a 24-bit-wide program memory through table read and table write requests. Each request carries a page value and an effective address; the unit joins them into a program address, treats address bit 0 as a byte selector inside the addressed word, and sees each 24-bit program word as two parallel spaces: a 16-bit low space (program bits 15:0) and an 8-bit high space (program bits 23:16) topped by a phantom byte that always reads as zero.

Reads go to a synchronous program memory read port. The returned word is cut down to the requested lane, zero filled, and registered onto a response port with a valid strobe. Writes go to a row holding latch as a lane-aligned 24-bit word with per-byte enables. The most significant page bit selects configuration space. Reads work in both spaces. Writes into configuration space are refused with a one-cycle error pulse.

Top module: `ptbl_access`

## Requirements
- R1: In the cycle a read request is presented, `mem_rd_en` is 1 and `mem_rd_addr` equals {page, ea[EA_W-1:1], 1'b0}; the word address advances by two per 24-bit word.
- R2: A read response appears with `rsp_valid` high for one cycle exactly two clock cycles after the request cycle, i.e. one cycle after the memory returns data; write requests never raise `rsp_valid`.
- R3: A low-space word read (hi=0, byte=0) returns program bits 15:0 on `rsp_data`.
- R4: A low-space byte read returns program bits 15:8 when ea[0]=1 and program bits 7:0 when ea[0]=0, placed in `rsp_data[7:0]`.
- R5: A high-space word read (hi=1, byte=0) returns program bits 23:16 in `rsp_data[7:0]` with `rsp_data[15:8]` zero.
- R6: A high-space byte read returns program bits 23:16 when ea[0]=0 and all zeros when ea[0]=1 (phantom byte).
- R7: For every byte-mode read, `rsp_data[15:8]` is zero.
- R8: Reads with page bit PAGE_W-1 set (configuration space) are served like user-space reads and never raise `rsp_err`.
- R9: Odd effective addresses are accepted for both words and bytes; a word access at an odd address reads the same word as the even address below it.
- R10: A user-space write raises `wr_en` one cycle after the request with `wr_addr` = {page, ea[EA_W-1:1], 1'b0}; lane enables `wr_be` are 3'b011 for a low word (data in bits 15:0), 3'b001 or 3'b010 for a low byte at ea[0]=0 or 1 (data in bits 7:0 or 15:8), and 3'b100 for a high word or a high byte at ea[0]=0 (data in bits 23:16); disabled lanes of `wr_data` are zero.
- R11: A high-space byte write at ea[0]=1 targets the phantom byte and produces neither `wr_en` nor `rsp_err`.
- R12: A write with page bit PAGE_W-1 set never raises `wr_en`; `rsp_err` is high for exactly the one cycle after the request.
- R13: After reset, `rsp_valid`, `rsp_err`, `wr_en` and `mem_rd_en` (with no request) are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_hi | input | 1 | 1 = high space (bits 23:16), 0 = low space (bits 15:0) |
| req_wr | input | 1 | 1 = table write, 0 = table read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_ea | input | EA_W | Effective address; bit 0 is the byte selector |
| req_page | input | PAGE_W | Table page; top bit selects configuration space |
| req_wdata | input | 16 | Write data (bytes use bits 7:0; high word uses bits 7:0) |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_rd_addr | output | PAGE_W+EA_W | Program memory word address |
| mem_rd_data | input | 24 | Program word, valid the cycle after `mem_rd_en` |
| wr_en | output | 1 | Holding latch write strobe |
| wr_addr | output | PAGE_W+EA_W | Holding latch word address |
| wr_data | output | 24 | Lane-aligned write word |
| wr_be | output | 3 | Per-byte lane enables (bit 0 = bits 7:0) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 16 | Read data |
| rsp_err | output | 1 | One-cycle pulse for a refused configuration-space write |

## Verification
The bench builds the unit with its default widths, an 8-bit page and a 16-bit effective address, so both states of the space-select bit and both parities of the byte selector are a single stimulus away. A bench memory model returns a word whose three bytes are distinct functions of the address, so any lane swap, missing zero fill or wrong address bit shows up as a mismatch. Configuration-space reads and writes, the phantom byte in both directions, and odd addresses for word and byte accesses are all driven directly.

// File: rtl/ptbl_pkg.sv
package ptbl_pkg;
  localparam int LO_W  = 16;
  localparam int HI_W  = 8;
  localparam int PW_W  = LO_W + HI_W;
  localparam int LANES = PW_W / 8;

  typedef struct packed {
    logic hi;
    logic bmode;
    logic bsel;
  } ptbl_sel_t;
endpackage

// File: rtl/ptbl_rst_sync.sv
module ptbl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptbl_addr_gen.sv
module ptbl_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16
) (
  input  logic [PAGE_W-1:0]      page,
  input  logic [EA_W-1:0]        ea,
  output logic [PAGE_W+EA_W-1:0] word_addr,
  output logic                   bsel,
  output logic                   cfg_space
);
  localparam int CFG_BIT = PAGE_W - 1;

  always_comb begin
    word_addr = {page, ea[EA_W-1:1], 1'b0};
    bsel      = ea[0];
    cfg_space = page[CFG_BIT];
  end
endmodule

// File: rtl/ptbl_rd_fmt.sv
module ptbl_rd_fmt
  import ptbl_pkg::*;
(
  input  ptbl_sel_t         sel,
  input  logic [PW_W-1:0]   word,
  output logic [LO_W-1:0]   data
);
  always_comb begin
    data = '0;
    unique case ({sel.hi, sel.bmode})
      2'b00: data = word[LO_W-1:0];
      2'b01: data[7:0] = sel.bsel ? word[15:8] : word[7:0];
      2'b10: data[HI_W-1:0] = word[PW_W-1:LO_W];
      2'b11: data[HI_W-1:0] = sel.bsel ? '0 : word[PW_W-1:LO_W];
      default: data = '0;
    endcase
  end
endmodule

// File: rtl/ptbl_wr_lane.sv
module ptbl_wr_lane
  import ptbl_pkg::*;
(
  input  ptbl_sel_t          sel,
  input  logic [LO_W-1:0]    wdata,
  output logic [PW_W-1:0]    lane_data,
  output logic [LANES-1:0]   lane_be
);
  always_comb begin
    lane_data = '0;
    lane_be   = '0;
    unique case ({sel.hi, sel.bmode})
      2'b00: begin
        lane_data[LO_W-1:0] = wdata;
        lane_be             = 3'b011;
      end
      2'b01: begin
        if (sel.bsel) begin
          lane_data[15:8] = wdata[7:0];
          lane_be         = 3'b010;
        end else begin
          lane_data[7:0]  = wdata[7:0];
          lane_be         = 3'b001;
        end
      end
      2'b10: begin
        lane_data[PW_W-1:LO_W] = wdata[HI_W-1:0];
        lane_be                = 3'b100;
      end
      2'b11: begin
        if (!sel.bsel) begin
          lane_data[PW_W-1:LO_W] = wdata[HI_W-1:0];
          lane_be                = 3'b100;
        end
      end
      default: begin
        lane_data = '0;
        lane_be   = '0;
      end
    endcase
  end
endmodule

// File: rtl/ptbl_access.sv
module ptbl_access
  import ptbl_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_hi,
  input  logic                   req_wr,
  input  logic                   req_byte,
  input  logic [EA_W-1:0]        req_ea,
  input  logic [PAGE_W-1:0]      req_page,
  input  logic [15:0]            req_wdata,
  output logic                   mem_rd_en,
  output logic [PAGE_W+EA_W-1:0] mem_rd_addr,
  input  logic [23:0]            mem_rd_data,
  output logic                   wr_en,
  output logic [PAGE_W+EA_W-1:0] wr_addr,
  output logic [23:0]            wr_data,
  output logic [2:0]             wr_be,
  output logic                   rsp_valid,
  output logic [15:0]            rsp_data,
  output logic                   rsp_err
);
  localparam int AW = PAGE_W + EA_W;

  logic            srst_n;
  logic [AW-1:0]   word_addr;
  logic            bsel;
  logic            cfg_space;
  ptbl_sel_t       req_sel;
  logic [PW_W-1:0] lane_data;
  logic [LANES-1:0] lane_be;
  logic [LO_W-1:0] fmt_data;

  // pipeline state
  logic            rd_p1_q, rd_p1_d;
  ptbl_sel_t       sel_p1_q;
  logic            rsp_valid_q, rsp_valid_d;
  logic [LO_W-1:0] rsp_data_q;
  logic            wr_en_q, wr_go;
  logic [AW-1:0]   wr_addr_q;
  logic [PW_W-1:0] wr_data_q;
  logic [LANES-1:0] wr_be_q;
  logic            err_q, wr_rej;

  ptbl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ptbl_addr_gen #(.PAGE_W(PAGE_W), .EA_W(EA_W)) u_addr (
    .page      (req_page),
    .ea        (req_ea),
    .word_addr (word_addr),
    .bsel      (bsel),
    .cfg_space (cfg_space)
  );

  ptbl_wr_lane u_wlane (
    .sel       (req_sel),
    .wdata     (req_wdata),
    .lane_data (lane_data),
    .lane_be   (lane_be)
  );

  ptbl_rd_fmt u_rfmt (
    .sel  (sel_p1_q),
    .word (mem_rd_data),
    .data (fmt_data)
  );

  // next-state logic
  always_comb begin
    req_sel.hi    = req_hi;
    req_sel.bmode = req_byte;
    req_sel.bsel  = bsel;
    rd_p1_d       = req_valid & ~req_wr;
    rsp_valid_d   = rd_p1_q;
    wr_rej        = req_valid & req_wr & cfg_space;
    wr_go         = req_valid & req_wr & ~cfg_space & (|lane_be);
  end

  assign mem_rd_en   = rd_p1_d;
  assign mem_rd_addr = word_addr;

  // control registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_p1_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      wr_en_q     <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rd_p1_q     <= rd_p1_d;
      rsp_valid_q <= rsp_valid_d;
      wr_en_q     <= wr_go;
      err_q       <= wr_rej;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      sel_p1_q   <= '0;
      rsp_data_q <= '0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      wr_be_q    <= '0;
    end else begin
      if (rd_p1_d) sel_p1_q   <= req_sel;
      if (rd_p1_q) rsp_data_q <= fmt_data;
      if (wr_go) begin
        wr_addr_q <= word_addr;
        wr_data_q <= lane_data;
        wr_be_q   <= lane_be;
      end
    end
  end

  assign wr_en     = wr_en_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign wr_be     = wr_be_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_err   = err_q;
endmodule

// File: rtl/ptbl_access_chk.sv
module ptbl_access_chk #(
  parameter int PAGE_W = 8,
  parameter int EA_W   = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_hi,
  input logic                   req_wr,
  input logic                   req_byte,
  input logic [EA_W-1:0]        req_ea,
  input logic [PAGE_W-1:0]      req_page,
  input logic                   mem_rd_en,
  input logic                   wr_en,
  input logic [2:0]             wr_be,
  input logic                   rsp_valid,
  input logic [15:0]            rsp_data,
  input logic                   rsp_err
);
  localparam int CFG_BIT = PAGE_W - 1;

  // R1
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_wr) |-> mem_rd_en);

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_wr, 2));

  // R6
  phantom_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid && !req_wr && req_hi && req_byte && req_ea[0], 2))
      |-> (rsp_data == 16'h0000));

  // R7
  byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid && !req_wr && (req_byte || req_hi), 2))
      |-> (rsp_data[15:8] == 8'h00));

  // R12
  cfg_wr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr && req_page[CFG_BIT]) |=> (rsp_err && !wr_en));

  // R8
  err_only_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(req_valid && req_wr && req_page[CFG_BIT]));

  // R10
  wr_lane_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_be != 3'b000));

  // R11
  phantom_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr && req_hi && req_byte && req_ea[0]) |=> !wr_en);
endmodule

bind ptbl_access ptbl_access_chk #(.PAGE_W(PAGE_W), .EA_W(EA_W)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .req_valid (req_valid),
  .req_hi    (req_hi),
  .req_wr    (req_wr),
  .req_byte  (req_byte),
  .req_ea    (req_ea),
  .req_page  (req_page),
  .mem_rd_en (mem_rd_en),
  .wr_en     (wr_en),
  .wr_be     (wr_be),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .rsp_err   (rsp_err)
);

// File: tb/ptbl_access_test.sv
`timescale 1ns/1ps
module ptbl_access_test;
  localparam int PAGE_W = 8;
  localparam int EA_W   = 16;
  localparam int AW     = PAGE_W + EA_W;

  logic              clk;
  logic              rst_n;
  logic              req_valid, req_hi, req_wr, req_byte;
  logic [EA_W-1:0]   req_ea;
  logic [PAGE_W-1:0] req_page;
  logic [15:0]       req_wdata;
  logic              mem_rd_en;
  logic [AW-1:0]     mem_rd_addr;
  logic [23:0]       mem_rd_data;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [23:0]       wr_data;
  logic [2:0]        wr_be;
  logic              rsp_valid;
  logic [15:0]       rsp_data;
  logic              rsp_err;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  ptbl_access #(.PAGE_W(PAGE_W), .EA_W(EA_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_hi(req_hi), .req_wr(req_wr), .req_byte(req_byte),
    .req_ea(req_ea), .req_page(req_page), .req_wdata(req_wdata),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [23:0] pat(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ 8'h3C, a[7:0] ^ a[23:16] ^ 8'h69};
  endfunction

  // synchronous program memory model
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_hi = 0; req_wr = 0; req_byte = 0;
    req_ea = '0; req_page = '0; req_wdata = '0;
  endtask

  function automatic logic [AW-1:0] waddr(input logic [PAGE_W-1:0] pg, input logic [EA_W-1:0] ea);
    return {pg, ea[EA_W-1:1], 1'b0};
  endfunction

  task automatic do_read(input string tag, input bit hi, input bit bm,
                         input logic [EA_W-1:0] ea, input logic [PAGE_W-1:0] pg,
                         input logic [15:0] exp);
    @(negedge clk);
    req_valid = 1; req_wr = 0; req_hi = hi; req_byte = bm; req_ea = ea; req_page = pg;
    #1;
    chk({tag, " R1 rd_en"}, mem_rd_en, 1);
    chk({tag, " R1 addr"}, mem_rd_addr, waddr(pg, ea));
    @(negedge clk);
    idle();
    chk({tag, " R2 early"}, rsp_valid, 0);
    @(negedge clk);
    chk({tag, " R2 valid"}, rsp_valid, 1);
    chk({tag, " data"}, rsp_data, exp);
    chk({tag, " R8 err"}, rsp_err, 0);
    @(negedge clk);
    chk({tag, " R2 one-cycle"}, rsp_valid, 0);
  endtask

  task automatic do_write(input string tag, input bit hi, input bit bm,
                          input logic [EA_W-1:0] ea, input logic [PAGE_W-1:0] pg,
                          input logic [15:0] wd, input bit exp_en, input bit exp_err,
                          input logic [2:0] exp_be, input logic [23:0] exp_data);
    @(negedge clk);
    req_valid = 1; req_wr = 1; req_hi = hi; req_byte = bm; req_ea = ea; req_page = pg;
    req_wdata = wd;
    @(negedge clk);
    idle();
    chk({tag, " wr_en"}, wr_en, exp_en);
    chk({tag, " err"}, rsp_err, exp_err);
    chk({tag, " R2 no rsp"}, rsp_valid, 0);
    if (exp_en) begin
      chk({tag, " R10 addr"}, wr_addr, waddr(pg, ea));
      chk({tag, " R10 be"}, wr_be, exp_be);
      chk({tag, " R10 data"}, wr_data, exp_data);
    end
    @(negedge clk);
    chk({tag, " one-cycle"}, {wr_en, rsp_err}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R13 rsp_valid", rsp_valid, 0);
    chk("R13 rsp_err", rsp_err, 0);
    chk("R13 wr_en", wr_en, 0);
    chk("R13 mem_rd_en", mem_rd_en, 0);
  endtask

  task automatic t_lo_word();
    do_read("R3 lo word", 0, 0, 16'h1234, 8'h05, pat(waddr(8'h05, 16'h1234))[15:0]);
    do_read("R3 lo word b", 0, 0, 16'hFFFE, 8'h7F, pat(waddr(8'h7F, 16'hFFFE))[15:0]);
  endtask

  task automatic t_lo_byte();
    do_read("R4 R7 lo byte0", 0, 1, 16'h0A40, 8'h12, {8'h00, pat(waddr(8'h12, 16'h0A40))[7:0]});
    do_read("R4 R7 lo byte1", 0, 1, 16'h0A41, 8'h12, {8'h00, pat(waddr(8'h12, 16'h0A41))[15:8]});
  endtask

  task automatic t_hi_word();
    do_read("R5 hi word", 1, 0, 16'h2200, 8'h33, {8'h00, pat(waddr(8'h33, 16'h2200))[23:16]});
  endtask

  task automatic t_hi_byte();
    do_read("R6 R7 hi byte0", 1, 1, 16'h5550, 8'h21, {8'h00, pat(waddr(8'h21, 16'h5550))[23:16]});
    do_read("R6 R7 hi phantom", 1, 1, 16'h5551, 8'h21, 16'h0000);
  endtask

  task automatic t_cfg_read();
    do_read("R8 cfg lo", 0, 0, 16'h0004, 8'hF8, pat(waddr(8'hF8, 16'h0004))[15:0]);
    do_read("R8 cfg hi", 1, 0, 16'h0006, 8'h80, {8'h00, pat(waddr(8'h80, 16'h0006))[23:16]});
  endtask

  task automatic t_unaligned();
    do_read("R9 odd word", 0, 0, 16'h3457, 8'h09, pat(waddr(8'h09, 16'h3456))[15:0]);
    do_read("R9 odd hi word", 1, 0, 16'h3457, 8'h09, {8'h00, pat(waddr(8'h09, 16'h3456))[23:16]});
  endtask

  task automatic t_wr_user();
    do_write("R10 lo word", 0, 0, 16'h0100, 8'h02, 16'hBEEF, 1, 0, 3'b011, 24'h00BEEF);
    do_write("R10 lo byte0", 0, 1, 16'h0102, 8'h02, 16'h77C4, 1, 0, 3'b001, 24'h0000C4);
    do_write("R10 lo byte1", 0, 1, 16'h0103, 8'h02, 16'h77C4, 1, 0, 3'b010, 24'h00C400);
    do_write("R10 hi word", 1, 0, 16'h0105, 8'h02, 16'h9A5D, 1, 0, 3'b100, 24'h5D0000);
    do_write("R10 hi byte0", 1, 1, 16'h0108, 8'h02, 16'h1166, 1, 0, 3'b100, 24'h660000);
  endtask

  task automatic t_wr_phantom();
    do_write("R11 phantom wr", 1, 1, 16'h0109, 8'h02, 16'h00FF, 0, 0, 3'b000, 24'h0);
  endtask

  task automatic t_wr_cfg();
    do_write("R12 cfg wr lo", 0, 0, 16'h0000, 8'h80, 16'h1234, 0, 1, 3'b000, 24'h0);
    do_write("R12 cfg wr hi", 1, 1, 16'h0010, 8'hFF, 16'h0055, 0, 1, 3'b000, 24'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lo_word();
    t_lo_byte();
    t_hi_word();
    t_hi_byte();
    t_cfg_read();
    t_unaligned();
    t_wr_user();
    t_wr_phantom();
    t_wr_cfg();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule